// File: doc/BRIEF.md
# Audio Bit Clock Divider with Selectable Ratio and Idle Stop

This block produces the serial bit clock of an audio interface in master mode. It works from an audio master clock, taken from one of two sources: an external audio clock input or a timer output. Both sources arrive as per-cycle edge strobes on the system clock `clk`. Each strobe marks one edge of the master clock, which is one master half-period. A 4-bit ratio code sets the divider to a power of two (1 to 128) or to six times a power of two (6 to 96). The output is a level `bck_out` with a 50% duty cycle, plus a one-cycle strobe `bck_tick` that marks the start of each bit period. Frame logic can use the strobe as a clock enable.

A supply enable gates the master clock into the divider. While the enable is low, the output is held low. The source select is sampled only while the supply is off, so the source cannot switch under a running divider. With auto-stop set, an idle indication from the interface parks the output low at the end of the current period. A new ratio code is picked up only at a period boundary, so no short pulse is produced.

The control is one state machine with four states. OFF means the supply is disabled. PARK means the output waits low for a start. HIGH is the first half of a bit period and LOW is the second half. Its transitions are:
- power-up: OFF to PARK.
- launch: PARK to HIGH on a master edge with no stop request.
- mid-period: HIGH to LOW after N master edges.
- wrap: LOW to HIGH after N master edges with no stop request.
- park: LOW to PARK after N master edges with a stop request.
- cut: any state to OFF when the supply is disabled.

Top module: `audio_bclk_divider`

## Requirements
- R1: Ratio codes 0 to 7 set N = 2^code. `bck_out` is high for N master edges, then low for N master edges, so one bit period is N master clock periods.
- R2: Ratio codes 8 to 12 set N = 6 * 2^(code-8), that is 6, 12, 24, 48 or 96, with the same high/low split as R1.
- R3: Ratio codes 13 to 15 are reserved and behave as code 0 (N = 1). The output then toggles on every master edge, which passes the master clock through.
- R4: While `mck_supply_en` is 0, `bck_out` is low and `bck_tick` is 0 from the first clock edge that samples the 0 onward.
- R5: `mck_src_sel` = 0 takes master edges from `mck_ext_tick` and 1 takes them from `mck_tmr_tick`. The select is captured only while the supply is disabled. A change while the supply is enabled has no effect on the output period.
- R6: With `auto_stop` = 0, `link_idle` is ignored. With `auto_stop` = 1 and `link_idle` = 1, the current period completes with its full high phase, then `bck_out` stays low with no `bck_tick`. Output resumes on a master edge once the request clears.
- R7: `bck_tick` is high for exactly the one clock cycle in which `bck_out` rises. It is high at no other time.
- R8: A change of `ratio_code` takes effect only at the next period start. The period in progress keeps its old length.
- R9: After reset, `bck_out` and `bck_tick` are 0 and the block is in OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mck_ext_tick | input | 1 | Edge strobe of the external audio master clock |
| mck_tmr_tick | input | 1 | Edge strobe of the timer-derived master clock |
| mck_src_sel | input | 1 | Master clock source: 0 external, 1 timer |
| mck_supply_en | input | 1 | Gates the master clock into the divider |
| ratio_code | input | 4 | Division ratio code |
| auto_stop | input | 1 | Enables stopping the bit clock while idle |
| link_idle | input | 1 | Interface idle indication |
| bck_tick | output | 1 | One-cycle strobe at each bit period start |
| bck_out | output | 1 | Divided bit clock level |

## Verification
`bck_out` and `bck_tick` come from one register stage. Both change on the same `clk` edge that samples a qualifying master edge strobe. A supply drop shows on `bck_out` after exactly one edge. The bench drives every input and samples every output at the falling edge, so each result is read half a cycle after the edge that produced it. With the selected source strobing on every other cycle, the bench expects a bit period of 4N cycles and a high phase of 2N cycles. It measures both from one `bck_tick` to the next, so it never relies on a fixed start offset.

// File: rtl/bclk_div_pkg.sv
package bclk_div_pkg;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 8;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_PARK = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } bclk_state_t;
endpackage

// File: rtl/bclk_ratio_decode.sv
module bclk_ratio_decode
    import bclk_div_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int NW = CNT_W
) (
    input  logic [CW-1:0] code,
    output logic [NW-1:0] half_len
);
    localparam int POW2_CODES = 8;
    localparam int SIX_LAST   = 12;

    always_comb begin
        if (int'(code) < POW2_CODES) begin
            half_len = NW'(1) << code[2:0];
        end else if (int'(code) <= SIX_LAST) begin
            half_len = NW'(6) << code[2:0];
        end else begin
            half_len = NW'(1);
        end
    end
endmodule

// File: rtl/bclk_src_select.sv
module bclk_src_select (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic sel_in,
    input  logic ext_tick,
    input  logic tmr_tick,
    output logic sel_q,
    output logic mtick
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (capture) begin
            sel_q <= sel_in;
        end
    end

    assign mtick = sel_q ? tmr_tick : ext_tick;
endmodule

// File: rtl/bclk_fsm.sv
module bclk_fsm
    import bclk_div_pkg::*;
#(
    parameter int NW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_en,
    input  logic          mtick,
    input  logic          stop_req,
    input  logic [NW-1:0] half_new,
    output logic          bck_out,
    output logic          bck_tick,
    output logic          is_off
);
    bclk_state_t   state, nxt;
    logic [NW-1:0] cnt, cnt_n;
    logic [NW-1:0] half_q, half_n;
    logic          tick_q, tick_n;
    logic          last_edge;

    assign last_edge = (cnt == half_q - NW'(1));

    always_comb begin
        nxt    = state;
        cnt_n  = cnt;
        half_n = half_q;
        tick_n = 1'b0;
        if (!supply_en) begin
            nxt   = ST_OFF;
            cnt_n = '0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    nxt   = ST_PARK;
                    cnt_n = '0;
                end
                ST_PARK: begin
                    if (mtick && !stop_req) begin
                        nxt    = ST_HIGH;
                        cnt_n  = '0;
                        half_n = half_new;
                        tick_n = 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (mtick) begin
                        if (last_edge) begin
                            nxt   = ST_LOW;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + NW'(1);
                        end
                    end
                end
                ST_LOW: begin
                    if (mtick) begin
                        if (last_edge) begin
                            cnt_n = '0;
                            if (stop_req) begin
                                nxt = ST_PARK;
                            end else begin
                                nxt    = ST_HIGH;
                                half_n = half_new;
                                tick_n = 1'b1;
                            end
                        end else begin
                            cnt_n = cnt + NW'(1);
                        end
                    end
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            cnt    <= '0;
            half_q <= NW'(1);
            tick_q <= 1'b0;
        end else begin
            state  <= nxt;
            cnt    <= cnt_n;
            half_q <= half_n;
            tick_q <= tick_n;
        end
    end

    always_comb begin
        bck_out  = (state == ST_HIGH);
        bck_tick = tick_q;
        is_off   = (state == ST_OFF);
    end
endmodule

// File: rtl/audio_bclk_divider.sv
module audio_bclk_divider
    import bclk_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mck_ext_tick,
    input  logic              mck_tmr_tick,
    input  logic              mck_src_sel,
    input  logic              mck_supply_en,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic              auto_stop,
    input  logic              link_idle,
    output logic              bck_tick,
    output logic              bck_out
);
    logic             mtick;
    logic             sel_eff;
    logic             in_off;
    logic [CNT_W-1:0] half_new;
    logic             stop_req;

    assign stop_req = auto_stop & link_idle;

    bclk_src_select i_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (in_off),
        .sel_in   (mck_src_sel),
        .ext_tick (mck_ext_tick),
        .tmr_tick (mck_tmr_tick),
        .sel_q    (sel_eff),
        .mtick    (mtick)
    );

    bclk_ratio_decode #(.CW(CODE_W), .NW(CNT_W)) i_dec (
        .code     (ratio_code),
        .half_len (half_new)
    );

    bclk_fsm #(.NW(CNT_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_en (mck_supply_en),
        .mtick     (mtick),
        .stop_req  (stop_req),
        .half_new  (half_new),
        .bck_out   (bck_out),
        .bck_tick  (bck_tick),
        .is_off    (in_off)
    );
endmodule

// File: rtl/audio_bclk_divider_chk.sv
module audio_bclk_divider_chk (
    input logic clk,
    input logic rst_n,
    input logic mck_supply_en,
    input logic mtick,
    input logic sel_eff,
    input logic in_off,
    input logic bck_tick,
    input logic bck_out
);
    AST_SUPPLY_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mck_supply_en |=> (!bck_out && !bck_tick)); // R4

    AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        bck_tick |-> $rose(bck_out)); // R7

    AST_RISE_HAS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bck_out) |-> bck_tick); // R7

    AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mck_supply_en && !mtick) |=> $stable(bck_out)); // R1

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_off |=> $stable(sel_eff)); // R5
endmodule

bind audio_bclk_divider audio_bclk_divider_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mck_supply_en (mck_supply_en),
    .mtick         (mtick),
    .sel_eff       (sel_eff),
    .in_off        (in_off),
    .bck_tick      (bck_tick),
    .bck_out       (bck_out)
);

// File: tb/test_audio_bclk_divider.sv
`timescale 1ns/1ps
module test_audio_bclk_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mck_ext_tick, mck_tmr_tick;
    logic       mck_src_sel = 1'b0;
    logic       mck_supply_en = 1'b0;
    logic [3:0] ratio_code = 4'd0;
    logic       auto_stop = 1'b0;
    logic       link_idle = 1'b0;
    logic       bck_tick, bck_out;
    logic       phase = 1'b0;
    logic       tb_src = 1'b0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;
    always @(negedge clk) phase <= ~phase;

    // Selected source strobes every other cycle; the other strobes every cycle.
    assign mck_ext_tick = (tb_src == 1'b0) ? phase : 1'b1;
    assign mck_tmr_tick = (tb_src == 1'b1) ? phase : 1'b1;

    audio_bclk_divider i_audio_bclk_divider (
        .clk(clk), .rst_n(rst_n),
        .mck_ext_tick(mck_ext_tick), .mck_tmr_tick(mck_tmr_tick),
        .mck_src_sel(mck_src_sel), .mck_supply_en(mck_supply_en),
        .ratio_code(ratio_code), .auto_stop(auto_stop), .link_idle(link_idle),
        .bck_tick(bck_tick), .bck_out(bck_out)
    );

    localparam int NV = 10;
    localparam logic [3:0] V_CODE [NV] = '{4'd0, 4'd1, 4'd3, 4'd7, 4'd8,
                                          4'd12, 4'd13, 4'd15, 4'd2, 4'd9};
    localparam bit V_SRC [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                  1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam int V_PER [NV] = '{4, 8, 32, 512, 24, 384, 4, 4, 16, 48};

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_tick(input string tag);
        int n = 0;
        @(negedge clk);
        while (!bck_tick && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!bck_tick) check(0, 1, {tag, " tick never seen"});
    endtask

    // Called at the sample showing a tick; returns at the next tick sample.
    task automatic count_period(output int per, output int high);
        per = 1;
        high = bck_out ? 1 : 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (bck_tick) break;
            per++;
            if (bck_out) high++;
        end
    endtask

    task automatic restart(input logic [3:0] code, input bit src);
        @(negedge clk);
        mck_supply_en = 1'b0;
        repeat (2) @(negedge clk);
        ratio_code  = code;
        tb_src      = src;
        mck_src_sel = src;
        @(negedge clk);
        mck_supply_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int per, high, seen_tick, seen_high;
        repeat (3) @(negedge clk);
        check(int'(bck_out), 0, "R9 bck_out in reset");
        check(int'(bck_tick), 0, "R9 bck_tick in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(int'(bck_out), 0, "R9 bck_out after reset, supply off");

        // Table walk: R1, R2, R3, R5 and R7 duty
        for (int v = 0; v < NV; v++) begin
            restart(V_CODE[v], V_SRC[v]);
            wait_tick("R1/R2 table");
            count_period(per, high);
            check(per, V_PER[v], $sformatf("R1 R2 R3 R5 period code %0d", V_CODE[v]));
            check(high, V_PER[v] / 2, $sformatf("R7 high phase code %0d", V_CODE[v]));
        end

        // R5: flipping the select while enabled has no effect
        restart(4'd2, 1'b0);
        wait_tick("R5");
        mck_src_sel = 1'b1;
        count_period(per, high);
        count_period(per, high);
        check(per, 16, "R5 select change while running");

        // R8: ratio change applies at next boundary
        restart(4'd1, 1'b0);
        wait_tick("R8");
        ratio_code = 4'd3;
        count_period(per, high);
        check(per, 8, "R8 current period keeps old ratio");
        count_period(per, high);
        check(per, 32, "R8 next period uses new ratio");

        // R6: idle ignored without auto-stop
        restart(4'd2, 1'b0);
        link_idle = 1'b1;
        auto_stop = 1'b0;
        wait_tick("R6");
        count_period(per, high);
        check(per, 16, "R6 idle ignored when auto_stop=0");

        // R6: auto-stop finishes the period then parks
        wait_tick("R6 stop");
        auto_stop = 1'b1;
        high = 1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (bck_out) high++;
        end
        check(high, 8, "R6 high phase completes before stop");
        seen_tick = 0;
        seen_high = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (bck_tick) seen_tick++;
            if (bck_out) seen_high++;
        end
        check(seen_tick, 0, "R6 no tick while parked");
        check(seen_high, 0, "R6 output low while parked");
        link_idle = 1'b0;
        wait_tick("R6 resume");
        count_period(per, high);
        check(per, 16, "R6 resumes after idle clears");

        // R4: supply disable forces output low
        wait_tick("R4");
        mck_supply_en = 1'b0;
        @(negedge clk);
        check(int'(bck_out), 0, "R4 output low one edge after disable");
        seen_tick = 0;
        seen_high = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (bck_tick) seen_tick++;
            if (bck_out) seen_high++;
        end
        check(seen_tick, 0, "R4 no tick while supply off");
        check(seen_high, 0, "R4 no high while supply off");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule